// File: doc/BRIEF.md
# SPI Slave Port with Receive Buffer and Service Flags

This block is a single SPI slave that sits next to a small register interface facing a local CPU. While the active-low select is held, the master's clock moves a word in on MOSI. At the same time the slave's preloaded transmit word goes out on MISO, most significant bit first. The word is 8 or 16 bits long, chosen by a configuration bit. MISO changes after each SCLK rising edge, and MOSI is sampled on each SCLK falling edge. The serial lines carry no acknowledge and no flow control.

When the final bit of a word is sampled, the block copies the received word into a receive buffer with no CPU action. The same event sets a buffer-full flag and an interrupt flag. Reading the buffer clears buffer-full. The interrupt flag is cleared only by a write-one-to-clear. If a word completes while buffer-full is still set, the buffer is overwritten and a sticky overflow bit is set.

SCLK, MOSI and the select line each pass through a two-flop synchronizer, and their edges are detected in the system clock domain. The system clock must therefore run several times faster than SCLK. Several words can follow one another under a single select. The transmit register is reloaded into the shifter when select is asserted and again after each completed word.

Top module: `spi_rxbuf_slave`

## Requirements
- R1: Config register (address 2) bit 0 selects the word length: 0 gives 8 bits and 1 gives 16 bits. Bits move most significant bit first in both directions.
- R2: The transmit word is written at address 0. It goes out on MISO while the master's word comes in on MOSI. A new MISO bit appears after each SCLK rising edge, and MOSI is sampled on each SCLK falling edge. In 8-bit mode only the low byte of the transmit word is sent.
- R3: MISO is driven low while the select input is high.
- R4: When the last bit of a word is sampled, the received word is placed in the receive buffer, zero-extended to 16 bits. Reading address 0 returns the buffer. The same event sets buffer-full (status bit 0 at address 1, pin rx_full) and the interrupt flag (status bit 1, pin irq).
- R5: A read of address 0 clears buffer-full and leaves the interrupt flag unchanged.
- R6: Writing 1 to status bit 1 clears the interrupt flag, and writing 1 to status bit 2 clears overflow. Writing 0 to either bit has no effect.
- R7: A word that completes while buffer-full is set overwrites the buffer and sets the sticky overflow bit (status bit 2).
- R8: Raising select in the middle of a word abandons that word. The buffer and the flags keep their values, and the next word starts again from its first bit.
- R9: SCLK edges that arrive while select is high neither shift data nor count bits.
- R10: After reset, all flags are 0, the buffer and the transmit word are 0, and the word length is 8 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than SCLK |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Serial clock from the master, idle low |
| spi_mosi | input | 1 | Serial data from the master |
| spi_ss_n | input | 1 | Active-low slave select |
| spi_miso | output | 1 | Serial data to the master |
| cpu_addr | input | 2 | Register address: 0 data, 1 status, 2 config |
| cpu_wr | input | 1 | Register write strobe |
| cpu_rd | input | 1 | Register read strobe; data is returned on the next cycle |
| cpu_wdata | input | 16 | Register write data |
| cpu_rdata | output | 16 | Register read data, registered |
| rx_full | output | 1 | Receive buffer holds an unread word |
| irq | output | 1 | Interrupt flag |

## Verification
The bench sends a word after two different sets of SCLK pulses. The first set stops part-way through a word by raising select; the second is pulsed while select is high. A design that kept the stale bit count would complete the next word early and store a word shifted out of place. Two words sent under one select, with no read between them, check that the transmit word is reloaded and that overflow is raised. A design that failed to reload would send zeros. A design that dropped overflow would leave status at 3 instead of 7. Reading the buffer, and separately writing 1 to each status bit, shows whether the clears stay independent: a design that tied the interrupt flag to the buffer read would lose the interrupt too early. The 8-bit and 16-bit exchanges catch a design that sends the wrong byte or fails to zero-extend.

// File: rtl/spi_slv_pkg.sv
package spi_slv_pkg;

  localparam int MAX_W = 16;
  localparam int MIN_W = 8;
  localparam int CNT_W = $clog2(MAX_W);
  localparam int LEN_W = CNT_W + 1;

  localparam logic [1:0] ADDR_DATA = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_CFG  = 2'd2;

  localparam int STAT_FULL = 0;
  localparam int STAT_IRQ  = 1;
  localparam int STAT_OVF  = 2;

  typedef struct packed {
    logic ovf;
    logic irq;
    logic full;
  } flags_t;

  function automatic logic [LEN_W-1:0] word_len(input logic wide);
    return wide ? LEN_W'(MAX_W) : LEN_W'(MIN_W);
  endfunction

  function automatic logic is_last_bit(input logic wide, input logic [CNT_W-1:0] cnt);
    return ({1'b0, cnt} == (word_len(wide) - LEN_W'(1)));
  endfunction

  // Short words are left-justified so the top bit always leaves first.
  function automatic logic [MAX_W-1:0] align_tx(input logic wide, input logic [MAX_W-1:0] w);
    return wide ? w : (w << (MAX_W - MIN_W));
  endfunction

  function automatic logic [MAX_W-1:0] trim_rx(input logic wide, input logic [MAX_W-1:0] w);
    return wide ? w : (w & MAX_W'((1 << MIN_W) - 1));
  endfunction

endpackage

// File: rtl/spi_slv_sync.sv
module spi_slv_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_in,
  output logic d_out
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[g] <= RST_VAL;
        else if (g == 0) chain[g] <= d_in;
        else chain[g] <= chain[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign d_out = chain[STAGES-1];
endmodule

// File: rtl/spi_slv_edge.sv
module spi_slv_edge #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic rise,
  output logic fall
);
  logic prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= RST_VAL;
    else prev <= d;
  end

  assign rise = d & ~prev;
  assign fall = ~d & prev;
endmodule

// File: rtl/spi_slv_shift.sv
module spi_slv_shift
  import spi_slv_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel,
  input  logic             sel_start,
  input  logic             sel_end,
  input  logic             sclk_rise,
  input  logic             sclk_fall,
  input  logic             mosi_s,
  input  logic             wide,
  input  logic [MAX_W-1:0] tx_word,
  output logic             miso_q,
  output logic [MAX_W-1:0] rx_word,
  output logic             word_done,
  output logic             word_abort,
  output logic [CNT_W-1:0] bit_cnt
);
  logic [MAX_W-1:0] tx_sh;
  logic [MAX_W-2:0] rx_sh;
  logic             shifting;
  logic             last;

  assign shifting   = sel & ~sel_start & ~sel_end;
  assign last       = is_last_bit(wide, bit_cnt);
  assign word_done  = shifting & sclk_fall & last;
  assign word_abort = sel_end & (bit_cnt != '0);
  assign rx_word    = trim_rx(wide, {rx_sh, mosi_s});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sh   <= '0;
      rx_sh   <= '0;
      bit_cnt <= '0;
      miso_q  <= 1'b0;
    end else if (sel_start) begin
      tx_sh   <= align_tx(wide, tx_word);
      rx_sh   <= '0;
      bit_cnt <= '0;
      miso_q  <= 1'b0;
    end else if (sel_end) begin
      bit_cnt <= '0;
      miso_q  <= 1'b0;
    end else if (shifting && sclk_rise) begin
      miso_q <= tx_sh[MAX_W-1];
      tx_sh  <= tx_sh << 1;
    end else if (shifting && sclk_fall) begin
      rx_sh <= {rx_sh[MAX_W-3:0], mosi_s};
      if (last) begin
        bit_cnt <= '0;
        tx_sh   <= align_tx(wide, tx_word);
      end else begin
        bit_cnt <= bit_cnt + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/spi_slv_regs.sv
module spi_slv_regs
  import spi_slv_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       cpu_addr,
  input  logic             cpu_wr,
  input  logic             cpu_rd,
  input  logic [MAX_W-1:0] cpu_wdata,
  output logic [MAX_W-1:0] cpu_rdata,
  input  logic             word_done,
  input  logic [MAX_W-1:0] rx_word,
  output logic [MAX_W-1:0] tx_word,
  output logic             wide,
  output flags_t           flags
);
  logic [MAX_W-1:0] rx_buf;
  logic             rd_buf;
  logic             wr_stat;

  assign rd_buf  = cpu_rd & (cpu_addr == ADDR_DATA);
  assign wr_stat = cpu_wr & (cpu_addr == ADDR_STAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_buf  <= '0;
      tx_word <= '0;
      wide    <= 1'b0;
      flags   <= '0;
    end else begin
      if (cpu_wr && cpu_addr == ADDR_DATA) tx_word <= cpu_wdata;
      if (cpu_wr && cpu_addr == ADDR_CFG)  wide    <= cpu_wdata[0];

      if (word_done) rx_buf <= rx_word;

      if (word_done)   flags.full <= 1'b1;
      else if (rd_buf) flags.full <= 1'b0;

      if (word_done) flags.irq <= 1'b1;
      else if (wr_stat && cpu_wdata[STAT_IRQ]) flags.irq <= 1'b0;

      if (word_done && flags.full && !rd_buf) flags.ovf <= 1'b1;
      else if (wr_stat && cpu_wdata[STAT_OVF]) flags.ovf <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpu_rdata <= '0;
    end else if (cpu_rd) begin
      case (cpu_addr)
        ADDR_DATA: cpu_rdata <= rx_buf;
        ADDR_STAT: cpu_rdata <= MAX_W'(flags);
        ADDR_CFG:  cpu_rdata <= MAX_W'(wide);
        default:   cpu_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/spi_rxbuf_slave.sv
module spi_rxbuf_slave
  import spi_slv_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             spi_sclk,
  input  logic             spi_mosi,
  input  logic             spi_ss_n,
  output logic             spi_miso,
  input  logic [1:0]       cpu_addr,
  input  logic             cpu_wr,
  input  logic             cpu_rd,
  input  logic [MAX_W-1:0] cpu_wdata,
  output logic [MAX_W-1:0] cpu_rdata,
  output logic             rx_full,
  output logic             irq
);
  logic             sclk_s, mosi_s, ss_n_s;
  logic             sclk_rise, sclk_fall;
  logic             sel, sel_start, sel_end;
  logic             miso_q;
  logic [MAX_W-1:0] rx_word, tx_word;
  logic             word_done, word_abort;
  logic [CNT_W-1:0] bit_cnt;
  logic             wide;
  flags_t           flags;
  logic             ovf_flag;

  spi_slv_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sclk (
    .clk(clk), .rst_n(rst_n), .d_in(spi_sclk), .d_out(sclk_s));
  spi_slv_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_mosi (
    .clk(clk), .rst_n(rst_n), .d_in(spi_mosi), .d_out(mosi_s));
  spi_slv_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_ss (
    .clk(clk), .rst_n(rst_n), .d_in(spi_ss_n), .d_out(ss_n_s));

  spi_slv_edge #(.RST_VAL(1'b0)) u_edge_sclk (
    .clk(clk), .rst_n(rst_n), .d(sclk_s), .rise(sclk_rise), .fall(sclk_fall));
  spi_slv_edge #(.RST_VAL(1'b1)) u_edge_ss (
    .clk(clk), .rst_n(rst_n), .d(ss_n_s), .rise(sel_end), .fall(sel_start));

  assign sel = ~ss_n_s;

  spi_slv_shift u_shift (
    .clk(clk), .rst_n(rst_n),
    .sel(sel), .sel_start(sel_start), .sel_end(sel_end),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
    .mosi_s(mosi_s), .wide(wide), .tx_word(tx_word),
    .miso_q(miso_q), .rx_word(rx_word),
    .word_done(word_done), .word_abort(word_abort), .bit_cnt(bit_cnt));

  spi_slv_regs u_regs (
    .clk(clk), .rst_n(rst_n),
    .cpu_addr(cpu_addr), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .word_done(word_done), .rx_word(rx_word),
    .tx_word(tx_word), .wide(wide), .flags(flags));

  assign spi_miso = ~spi_ss_n & miso_q;
  assign rx_full  = flags.full;
  assign irq      = flags.irq;
  assign ovf_flag = flags.ovf;
endmodule

// File: rtl/spi_rxbuf_slave_chk.sv
module spi_rxbuf_slave_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       word_done,
  input logic       word_abort,
  input logic       sel,
  input logic [1:0] cpu_addr,
  input logic       cpu_wr,
  input logic       cpu_rd,
  input logic       w1c_irq,
  input logic       w1c_ovf,
  input logic       rx_full,
  input logic       irq,
  input logic       ovf_flag
);
  logic rd_buf, stat_irq_clr, stat_ovf_clr;
  assign rd_buf       = cpu_rd & (cpu_addr == 2'd0);
  assign stat_irq_clr = cpu_wr & (cpu_addr == 2'd1) & w1c_irq;
  assign stat_ovf_clr = cpu_wr & (cpu_addr == 2'd1) & w1c_ovf;

  AST_DONE_SETS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    word_done |=> (rx_full && irq)); // R4
  AST_READ_CLEARS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_buf && !word_done) |=> !rx_full); // R5
  AST_READ_KEEPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_buf && irq && !stat_irq_clr) |=> irq); // R5
  AST_IRQ_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_irq_clr && !word_done) |=> !irq); // R6
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !stat_ovf_clr) |=> ovf_flag); // R7
  AST_OVF_ON_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (word_done && rx_full && !rd_buf) |=> ovf_flag); // R7
  AST_ABORT_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    word_abort |-> !word_done); // R8
  AST_DONE_ONLY_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    word_done |-> sel); // R9
endmodule

bind spi_rxbuf_slave spi_rxbuf_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n),
  .word_done(word_done), .word_abort(word_abort), .sel(sel),
  .cpu_addr(cpu_addr), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
  .w1c_irq(cpu_wdata[1]), .w1c_ovf(cpu_wdata[2]),
  .rx_full(rx_full), .irq(irq), .ovf_flag(ovf_flag));

// File: tb/spi_rxbuf_slave_test.sv
module spi_rxbuf_slave_test;
  localparam int HALF = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        spi_sclk = 1'b0, spi_mosi = 1'b0, spi_ss_n = 1'b1;
  logic        spi_miso;
  logic [1:0]  cpu_addr = 2'd0;
  logic        cpu_wr = 1'b0, cpu_rd = 1'b0;
  logic [15:0] cpu_wdata = '0;
  logic [15:0] cpu_rdata;
  logic        rx_full, irq;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 0;

  logic [15:0] exp_q[$];
  logic [15:0] got_q[$];
  string       req_q[$];
  event        got_ev;

  always #2 clk = ~clk;

  spi_rxbuf_slave uut (
    .clk(clk), .rst_n(rst_n),
    .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_ss_n(spi_ss_n), .spi_miso(spi_miso),
    .cpu_addr(cpu_addr), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .rx_full(rx_full), .irq(irq));

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic reg_wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  task automatic reg_rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_rd = 1'b1;
    @(negedge clk);
    cpu_rd = 1'b0;
    d = cpu_rdata;
  endtask

  // Master side: drive on rising, capture MISO just before falling.
  task automatic spi_bits(input logic [15:0] w, input int nbits, output logic [15:0] got);
    got = '0;
    for (int i = nbits - 1; i >= 0; i--) begin
      spi_sclk = 1'b1;
      spi_mosi = w[i];
      wait_clk(HALF);
      got[i] = spi_miso;
      spi_sclk = 1'b0;
      wait_clk(HALF);
    end
  endtask

  // Driver: pushes the expected MISO word, runs the exchange, hands the result to the monitor.
  task automatic send_word(input logic [15:0] w, input int nbits,
                           input logic [15:0] exp_miso, input string req);
    logic [15:0] got;
    exp_q.push_back(exp_miso);
    req_q.push_back(req);
    spi_bits(w, nbits, got);
    got_q.push_back(got);
    -> got_ev;
  endtask

  task automatic select(input logic on);
    @(negedge clk);
    spi_ss_n = ~on;
    wait_clk(HALF);
  endtask

  // Monitor: compares what the master captured against the scoreboard.
  initial begin
    forever begin
      @(got_ev);
      while (got_q.size() != 0 && exp_q.size() != 0)
        check(req_q.pop_front(), got_q.pop_front(), exp_q.pop_front());
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(4);

    // R10 reset state, R3 MISO low while deselected
    check("R10 rx_full", 16'(rx_full), 16'h0);
    check("R10 irq", 16'(irq), 16'h0);
    check("R3 miso idle", 16'(spi_miso), 16'h0);
    reg_rd(2'd1, d); check("R10 status", d, 16'h0000);
    reg_rd(2'd2, d); check("R10 config 8-bit", d, 16'h0000);
    reg_rd(2'd0, d); check("R10 buffer", d, 16'h0000);

    // R1 R2 R4: 8-bit exchange, only the low byte of the transmit word leaves
    reg_wr(2'd0, 16'h77A5);
    select(1'b1);
    send_word(16'h003C, 8, 16'h00A5, "R2 miso 8-bit");
    select(1'b0);
    check("R3 miso after deselect", 16'(spi_miso), 16'h0);
    check("R4 rx_full pin", 16'(rx_full), 16'h1);
    check("R4 irq pin", 16'(irq), 16'h1);
    reg_rd(2'd1, d); check("R4 status full+irq", d, 16'h0003);

    // R5 read clears full only
    reg_rd(2'd0, d); check("R4 buffer 8-bit", d, 16'h003C);
    reg_rd(2'd1, d); check("R5 status after read", d, 16'h0002);

    // R6 writing 0 does nothing, writing 1 clears irq
    reg_wr(2'd1, 16'h0000);
    reg_rd(2'd1, d); check("R6 zero write ignored", d, 16'h0002);
    reg_wr(2'd1, 16'h0002);
    reg_rd(2'd1, d); check("R6 irq cleared", d, 16'h0000);
    check("R6 irq pin low", 16'(irq), 16'h0);

    // R1 16-bit exchange
    reg_wr(2'd2, 16'h0001);
    reg_rd(2'd2, d); check("R1 config 16-bit", d, 16'h0001);
    reg_wr(2'd0, 16'hC3E1);
    select(1'b1);
    send_word(16'h9A5F, 16, 16'hC3E1, "R1 miso 16-bit");
    select(1'b0);
    reg_rd(2'd0, d); check("R1 buffer 16-bit", d, 16'h9A5F);
    reg_wr(2'd1, 16'h0006);

    // R7 two words under one select without a read: reload and overflow
    reg_wr(2'd2, 16'h0000);
    reg_wr(2'd0, 16'h0081);
    select(1'b1);
    send_word(16'h00F0, 8, 16'h0081, "R2 miso first word");
    send_word(16'h0055, 8, 16'h0081, "R2 miso reloaded word");
    select(1'b0);
    reg_rd(2'd1, d); check("R7 status overflow", d, 16'h0007);
    reg_rd(2'd0, d); check("R7 buffer overwritten", d, 16'h0055);
    reg_rd(2'd1, d); check("R7 overflow sticky", d, 16'h0006);
    reg_wr(2'd1, 16'h0004);
    reg_rd(2'd1, d); check("R6 overflow cleared", d, 16'h0002);
    reg_wr(2'd1, 16'h0002);

    // R8 abort mid-word, then a full word starts from its first bit
    select(1'b1);
    spi_bits(16'h001F, 5, d);
    select(1'b0);
    reg_rd(2'd1, d); check("R8 status after abort", d, 16'h0000);
    select(1'b1);
    send_word(16'h00B6, 8, 16'h0081, "R8 miso after abort");
    select(1'b0);
    reg_rd(2'd0, d); check("R8 buffer after abort", d, 16'h00B6);
    reg_wr(2'd1, 16'h0006);

    // R9 clocks while deselected are ignored
    spi_bits(16'h003F, 6, d);
    wait_clk(HALF);
    reg_rd(2'd1, d); check("R9 status after idle clocks", d, 16'h0000);
    select(1'b1);
    send_word(16'h00C9, 8, 16'h0081, "R9 miso after idle clocks");
    select(1'b0);
    reg_rd(2'd0, d); check("R9 buffer after idle clocks", d, 16'h00C9);
    reg_rd(2'd1, d); check("R9 status single word", d, 16'h0002);

    wait_clk(4);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule